// File: doc/BRIEF.md
# Asynchronous NAND Host Bus Sequencer

This block is the host side of a single-data-rate NAND flash bus that has no clock. A user issues one bus cycle at a time: a command byte, an address byte, a write-data byte or a read-data byte. The block then produces chip select, the two latch-enable levels that mark the cycle type, and a write or read strobe whose low and high widths come from configuration inputs counted in system clocks. Bytes leave on the shared 8-bit bus, which the host drives with an output enable. During read cycles it lets go of the bus and samples the byte the flash returns.

A request can ask to wait until the flash reports ready. The ready/busy line is brought into the clock domain through a synchronizer. If the flash stays busy too long the request ends with an error and no bus activity. A write-protect control sets the protect pin, and it refuses any request marked as program or erase while protection is on. Every request ends with a one-clock `done` pulse. A read request also raises `rd_valid` with the sampled byte in that same clock.

Top module: `nand_bus_seq`

## Requirements
- R1: While reset is held, chip select, write strobe and read strobe are high, both latch enables are low, the bus output enable is low, `busy` and `done` are low, and the protect pin `nand_wp_n` is low.
- R2: `req_kind` encodes the cycle type. 0 is a command (command-latch high, address-latch low). 1 is an address (address-latch high, command-latch low). 2 is write data and 3 is read data, both with both latch enables low. These levels are held at the rising edge of the strobe.
- R3: For kinds 0 to 2, at the rising edge of the write strobe the bus carries `req_byte`, the output enable is high, and chip select is low.
- R4: For kind 3 the read strobe is used, the output enable stays low, and `rd_data` equals the bus input value present at the rising edge of the read strobe. `rd_valid` is high only in the clock that `done` is high.
- R5: With Lo = max(`cfg_low`,2) and Hi = max(`cfg_high`,2), the strobe is low for exactly Lo clocks. Chip select is low for 1+Lo+Hi clocks. `done` appears 1+Lo+Hi clocks after the accepting edge when no wait is requested.
- R6: Chip select is high whenever no cycle is in progress. The write and read strobes are never low together, and never low while chip select is high.
- R7: With `req_wait_rdy` set and the synchronized ready line already high, the cycle starts one clock later, so `done` comes after 2+Lo+Hi clocks.
- R8: With `req_wait_rdy` set and the ready line held low, the request ends after max(`cfg_timeout`,1) clocks with `done` and `err` high. Chip select and the strobes stay high.
- R9: If the synchronized ready line goes high in the same clock that the timeout would expire, ready wins and the cycle runs without error.
- R10: `nand_wp_n` follows the inverse of `wp_on` one clock later. A request with `req_prog` set while `wp_on` is high ends on the accepting edge with `done` and `err` and no bus activity. Requests without `req_prog` run normally under protection.
- R11: `req_valid` is ignored while `busy` is high: no extra strobe occurs, and the byte of the running cycle is unchanged.
- R12: `done` is a one-clock pulse, and `busy` is low in the clock that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_kind | input | 2 | Cycle type (0 cmd, 1 addr, 2 write, 3 read) |
| req_byte | input | DW | Byte for command, address or write |
| req_wait_rdy | input | 1 | Wait for flash ready before the cycle |
| req_prog | input | 1 | Request belongs to a program or erase |
| wp_on | input | 1 | Write-protect control |
| cfg_low | input | CW | Strobe low width in clocks |
| cfg_high | input | CW | Strobe high width in clocks |
| cfg_timeout | input | TW | Ready-wait limit in clocks |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Completion was a timeout or protect refusal |
| rd_valid | output | 1 | Read byte valid, with done |
| rd_data | output | DW | Sampled read byte |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect pin, active low |
| nand_rb_n | input | 1 | Ready/busy from flash, low is busy |
| nand_dq_o | output | DW | Bus value driven by host |
| nand_dq_oe | output | 1 | Host bus output enable |
| nand_dq_i | input | DW | Bus value returned by flash |

## Verification
The ready-wait counter expiring and the synchronized ready line rising can land on the same clock. The bench provokes this by raising the ready pin at a chosen negative edge during a wait with a limit of six. It counts the synchronizer's two stages so that the first high sample reaches the sequencer exactly on the expiry edge. In that case it expects no error and a full cycle. It then repeats with the pin raised one clock later and expects the timeout error after exactly six clocks. A second overlap arises when a new request arrives during a running cycle. The bench judges that one by counting write-strobe rises seen by its flash model and by comparing the captured byte.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_WDATA = 2'd2,
        KIND_RDATA = 2'd3
    } nbs_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETUP,
        ST_LOW,
        ST_HIGH
    } nbs_state_e;

endpackage

// File: rtl/nbs_sync.sv
module nbs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    for (genvar i = 0; i < STAGES; i++) begin : g_st
        logic r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= g_st[i-1].r;
            end
        end
    end

    assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/nbs_cfg.sv
module nbs_cfg #(
    parameter int CW        = 8,
    parameter int TW        = 16,
    parameter int MIN_PULSE = 2,
    parameter int MIN_WAIT  = 1
) (
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_high,
    input  logic [TW-1:0] cfg_timeout,
    output logic [CW-1:0] eff_low,
    output logic [CW-1:0] eff_high,
    output logic [TW-1:0] eff_to
);
    localparam logic [CW-1:0] PULSE_FLOOR = CW'(MIN_PULSE);
    localparam logic [TW-1:0] WAIT_FLOOR  = TW'(MIN_WAIT);

    always_comb begin
        eff_low  = (cfg_low  < PULSE_FLOOR) ? PULSE_FLOOR : cfg_low;
        eff_high = (cfg_high < PULSE_FLOOR) ? PULSE_FLOOR : cfg_high;
        eff_to   = (cfg_timeout < WAIT_FLOOR) ? WAIT_FLOOR : cfg_timeout;
    end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nbs_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8,
    parameter int TW = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_byte,
    input  logic          req_wait_rdy,
    input  logic          req_prog,
    input  logic          wp_on,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_high,
    input  logic [TW-1:0] cfg_timeout,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          nand_ce_n,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic          nand_wp_n,
    input  logic          nand_rb_n,
    output logic [DW-1:0] nand_dq_o,
    output logic          nand_dq_oe,
    input  logic [DW-1:0] nand_dq_i
);
    localparam int NW = (CW > TW) ? CW : TW;

    typedef struct packed {
        nbs_state_e    state;
        nbs_kind_e     kind;
        logic [NW-1:0] cnt;
        logic [CW-1:0] low_len;
        logic [CW-1:0] high_len;
        logic [DW-1:0] data;
        logic          ce_n;
        logic          cle;
        logic          ale;
        logic          we_n;
        logic          re_n;
        logic          wp_n;
        logic          dq_oe;
        logic          done;
        logic          err;
        logic          rd_valid;
        logic [DW-1:0] rd_data;
    } seq_t;

    seq_t q, d;

    logic          rb_ready;
    logic [CW-1:0] eff_low, eff_high;
    logic [TW-1:0] eff_to;

    nbs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nand_rb_n),
        .q     (rb_ready)
    );

    nbs_cfg #(.CW(CW), .TW(TW), .MIN_PULSE(2), .MIN_WAIT(1)) u_cfg (
        .cfg_low     (cfg_low),
        .cfg_high    (cfg_high),
        .cfg_timeout (cfg_timeout),
        .eff_low     (eff_low),
        .eff_high    (eff_high),
        .eff_to      (eff_to)
    );

    function automatic seq_t open_cycle(seq_t s);
        seq_t r;
        r       = s;
        r.state = ST_SETUP;
        r.ce_n  = 1'b0;
        r.cle   = (s.kind == KIND_CMD);
        r.ale   = (s.kind == KIND_ADDR);
        r.dq_oe = (s.kind != KIND_RDATA);
        r.cnt   = '0;
        return r;
    endfunction

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.err      = 1'b0;
        d.rd_valid = 1'b0;
        d.wp_n     = ~wp_on;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.kind     = nbs_kind_e'(req_kind);
                    d.data     = req_byte;
                    d.low_len  = eff_low;
                    d.high_len = eff_high;
                    d.cnt      = '0;
                    if (req_prog && wp_on) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else if (req_wait_rdy) begin
                        d.state = ST_WAIT;
                    end else begin
                        d = open_cycle(d);
                    end
                end
            end
            ST_WAIT: begin
                if (rb_ready) begin
                    d = open_cycle(d);
                end else if (NW'(q.cnt + 1'b1) >= NW'(eff_to)) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.err   = 1'b1;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SETUP: begin
                d.state = ST_LOW;
                d.cnt   = NW'(1);
                if (q.kind == KIND_RDATA) d.re_n = 1'b0;
                else                      d.we_n = 1'b0;
            end
            ST_LOW: begin
                if (q.cnt >= NW'(q.low_len)) begin
                    d.state = ST_HIGH;
                    d.cnt   = NW'(1);
                    d.we_n  = 1'b1;
                    d.re_n  = 1'b1;
                    if (q.kind == KIND_RDATA) d.rd_data = nand_dq_i;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_HIGH: begin
                if (q.cnt >= NW'(q.high_len)) begin
                    d.state    = ST_IDLE;
                    d.cnt      = '0;
                    d.ce_n     = 1'b1;
                    d.cle      = 1'b0;
                    d.ale      = 1'b0;
                    d.dq_oe    = 1'b0;
                    d.done     = 1'b1;
                    d.rd_valid = (q.kind == KIND_RDATA);
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.kind     <= KIND_CMD;
            q.ce_n     <= 1'b1;
            q.we_n     <= 1'b1;
            q.re_n     <= 1'b1;
            q.wp_n     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.state != ST_IDLE);
    assign done       = q.done;
    assign err        = q.err;
    assign rd_valid   = q.rd_valid;
    assign rd_data    = q.rd_data;
    assign nand_ce_n  = q.ce_n;
    assign nand_cle   = q.cle;
    assign nand_ale   = q.ale;
    assign nand_we_n  = q.we_n;
    assign nand_re_n  = q.re_n;
    assign nand_wp_n  = q.wp_n;
    assign nand_dq_o  = q.data;
    assign nand_dq_oe = q.dq_oe;
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wp_on,
    input logic          busy,
    input logic          done,
    input logic          rd_valid,
    input logic          nand_ce_n,
    input logic          nand_cle,
    input logic          nand_ale,
    input logic          nand_we_n,
    input logic          nand_re_n,
    input logic          nand_wp_n,
    input logic          nand_dq_oe,
    input logic [DW-1:0] nand_dq_o
);
    p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_dq_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> ($stable(nand_dq_o) && nand_dq_oe && !nand_ce_n));

    p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    p_rdvalid_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> done);

    p_min_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (!$past(nand_we_n, 1) && !$past(nand_we_n, 2)));

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_strobe_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    p_wp_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wp_on |=> !nand_wp_n);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind nand_bus_seq nbs_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_on      (wp_on),
    .busy       (busy),
    .done       (done),
    .rd_valid   (rd_valid),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_wp_n  (nand_wp_n),
    .nand_dq_oe (nand_dq_oe),
    .nand_dq_o  (nand_dq_o)
);

// File: tb/tb_nand_bus_seq.sv
module tb_nand_bus_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [7:0]  req_byte = 8'd0;
    logic        req_wait_rdy = 1'b0;
    logic        req_prog = 1'b0;
    logic        wp_on = 1'b0;
    logic [7:0]  cfg_low = 8'd2;
    logic [7:0]  cfg_high = 8'd2;
    logic [15:0] cfg_timeout = 16'd4;
    logic        nand_rb_n = 1'b1;
    logic [7:0]  nand_dq_i = 8'h11;
    logic        busy, done, err, rd_valid;
    logic [7:0]  rd_data, nand_dq_o;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_dq_oe;

    nand_bus_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_byte(req_byte), .req_wait_rdy(req_wait_rdy), .req_prog(req_prog),
        .wp_on(wp_on), .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_timeout(cfg_timeout),
        .busy(busy), .done(done), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .nand_rb_n(nand_rb_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // flash-side model: latch what the bus shows at each strobe rise
    int         we_rises = 0, re_rises = 0;
    logic [7:0] cap_dq, cap_rd;
    logic       cap_cle, cap_ale, cap_oe, cap_ce, cap_oe_rd;

    always @(negedge clk) nand_dq_i <= nand_dq_i + 8'd37;

    always @(posedge nand_we_n) if (rst_n) begin
        we_rises++;
        cap_dq = nand_dq_o; cap_cle = nand_cle; cap_ale = nand_ale;
        cap_oe = nand_dq_oe; cap_ce = nand_ce_n;
    end

    always @(posedge nand_re_n) if (rst_n) begin
        re_rises++;
        cap_rd = nand_dq_i; cap_oe_rd = nand_dq_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int floor_at(input int v, input int m);
        return (v < m) ? m : v;
    endfunction

    int busy_bad = 0;

    task automatic run(input logic [1:0] k, input logic [7:0] b, input bit w, input bit pe,
                       input int lo, input int hi, input int tmo, input int rise_at,
                       input bit poke, output int n, output int ce_lo, output int we_lo,
                       output int re_lo, output bit e, output bit rv, output logic [7:0] rd);
        @(negedge clk);
        cfg_low = 8'(lo); cfg_high = 8'(hi); cfg_timeout = 16'(tmo);
        req_kind = k; req_byte = b; req_wait_rdy = w; req_prog = pe; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; ce_lo = 0; we_lo = 0; re_lo = 0;
        while (!done && n < 2000) begin
            if (!busy) busy_bad++;
            if (!nand_ce_n) ce_lo++;
            if (!nand_we_n) we_lo++;
            if (!nand_re_n) re_lo++;
            if (n == rise_at) nand_rb_n = 1'b1;
            if (poke && n == 1) begin req_valid = 1'b1; req_byte = ~b; end
            if (poke && n == 2) req_valid = 1'b0;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        e = err; rv = rd_valid; rd = rd_data;
        chk(!busy, "R12 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(!done, "R12 done one clock", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n, ce_lo, we_lo, re_lo, we0, re0;
        bit e, rv;
        logic [7:0] rd;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes/select high", 0, 1);
        chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latch/oe low", 0, 0);
        chk(!busy && !done, "R1 busy/done low", int'(busy), 0);
        chk(!nand_wp_n, "R1 protect pin low", int'(nand_wp_n), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(nand_ce_n, "R6 select high when idle", int'(nand_ce_n), 1);
        chk(nand_wp_n, "R10 protect pin follows wp_on", int'(nand_wp_n), 1);

        // sweep kinds and widths
        for (int k = 0; k < 4; k++) begin
            for (int lo = 0; lo < 5; lo++) begin
                for (int hi = 0; hi < 5; hi++) begin
                    int el, eh;
                    logic [7:0] b;
                    el = floor_at(lo, 2); eh = floor_at(hi, 2);
                    b = 8'(k * 61 + lo * 7 + hi * 3 + 5);
                    we0 = we_rises; re0 = re_rises;
                    run(2'(k), b, 1'b0, 1'b0, lo, hi, 4, -1, 1'b0, n, ce_lo, we_lo, re_lo, e, rv, rd);
                    chk(n == 1 + el + eh, "R5 cycle length", n, 1 + el + eh);
                    chk(ce_lo == 1 + el + eh, "R5 select low length", ce_lo, 1 + el + eh);
                    chk(!e, "R5 no error", int'(e), 0);
                    if (k != 3) begin
                        chk(we_lo == el, "R5 write strobe low width", we_lo, el);
                        chk(re_lo == 0, "R6 no read strobe on write", re_lo, 0);
                        chk(we_rises - we0 == 1, "R3 one write strobe", we_rises - we0, 1);
                        chk(cap_dq == b, "R3 bus byte at strobe rise", int'(cap_dq), int'(b));
                        chk(cap_oe && !cap_ce, "R3 driven and selected", int'(cap_oe), 1);
                        chk(cap_cle == (k == 0), "R2 command latch level", int'(cap_cle), int'(k == 0));
                        chk(cap_ale == (k == 1), "R2 address latch level", int'(cap_ale), int'(k == 1));
                        chk(!rv, "R4 no read valid on write", int'(rv), 0);
                    end else begin
                        chk(re_lo == el, "R5 read strobe low width", re_lo, el);
                        chk(we_lo == 0, "R6 no write strobe on read", we_lo, 0);
                        chk(re_rises - re0 == 1, "R4 one read strobe", re_rises - re0, 1);
                        chk(!cap_oe_rd, "R4 bus released", int'(cap_oe_rd), 0);
                        chk(rv, "R4 read valid with done", int'(rv), 1);
                        chk(rd == cap_rd, "R4 sampled byte", int'(rd), int'(cap_rd));
                    end
                end
            end
        end

        // R10 write protect
        @(negedge clk); wp_on = 1'b1;
        @(negedge clk);
        chk(!nand_wp_n, "R10 protect pin low", int'(nand_wp_n), 0);
        we0 = we_rises;
        run(2'd0, 8'h60, 1'b0, 1'b1, 2, 2, 4, -1, 1'b0, n, ce_lo, we_lo, re_lo, e, rv, rd);
        chk(n == 0 && e, "R10 refused on accept edge", n, 0);
        chk(ce_lo == 0 && we_rises == we0, "R10 no bus activity", we_rises - we0, 0);
        run(2'd0, 8'h70, 1'b0, 1'b0, 2, 2, 4, -1, 1'b0, n, ce_lo, we_lo, re_lo, e, rv, rd);
        chk(n == 5 && !e && cap_dq == 8'h70, "R10 plain request runs", n, 5);
        @(negedge clk); wp_on = 1'b0;
        run(2'd0, 8'hD0, 1'b0, 1'b1, 3, 2, 4, -1, 1'b0, n, ce_lo, we_lo, re_lo, e, rv, rd);
        chk(n == 6 && !e && cap_dq == 8'hD0, "R10 allowed when unprotected", n, 6);

        // R7 wait with ready already high
        nand_rb_n = 1'b1; repeat (3) @(negedge clk);
        run(2'd2, 8'hA5, 1'b1, 1'b0, 3, 2, 8, -1, 1'b0, n, ce_lo, we_lo, re_lo, e, rv, rd);
        chk(n == 7, "R7 one clock of wait", n, 7);
        chk(ce_lo == 6 && !e, "R7 select low length", ce_lo, 6);

        // R8 timeout sweep
        for (int t = 0; t < 6; t++) begin
            nand_rb_n = 1'b0; repeat (3) @(negedge clk);
            we0 = we_rises;
            run(2'd0, 8'hFF, 1'b1, 1'b0, 2, 2, t, -1, 1'b0, n, ce_lo, we_lo, re_lo, e, rv, rd);
            chk(n == floor_at(t, 1), "R8 timeout length", n, floor_at(t, 1));
            chk(e, "R8 error flagged", int'(e), 1);
            chk(ce_lo == 0 && we_rises == we0, "R8 no bus activity", ce_lo, 0);
        end

        // R9 ready arriving on the expiry clock
        nand_rb_n = 1'b0; repeat (3) @(negedge clk);
        run(2'd1, 8'h3C, 1'b1, 1'b0, 2, 2, 6, 3, 1'b0, n, ce_lo, we_lo, re_lo, e, rv, rd);
        chk(!e, "R9 ready wins over timeout", int'(e), 0);
        chk(n == 11 && cap_dq == 8'h3C, "R9 cycle runs", n, 11);
        nand_rb_n = 1'b0; repeat (3) @(negedge clk);
        run(2'd1, 8'h3D, 1'b1, 1'b0, 2, 2, 6, 4, 1'b0, n, ce_lo, we_lo, re_lo, e, rv, rd);
        chk(e && n == 6, "R9 one clock late times out", n, 6);
        repeat (3) @(negedge clk);

        // R11 request during a running cycle
        we0 = we_rises;
        run(2'd2, 8'h5A, 1'b0, 1'b0, 3, 3, 4, -1, 1'b1, n, ce_lo, we_lo, re_lo, e, rv, rd);
        chk(we_rises - we0 == 1, "R11 no extra strobe", we_rises - we0, 1);
        chk(cap_dq == 8'h5A, "R11 byte unchanged", int'(cap_dq), 8'h5A);
        repeat (3) @(negedge clk);
        chk(nand_ce_n && !busy, "R11 nothing started later", int'(nand_ce_n), 1);

        chk(busy_bad == 0, "R12 busy through cycle", busy_bad, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule